// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt inputs, keeps them in a request register, and passes them to a processor one at a time under fixed priority. Input 0 has the highest priority. Software reaches it through a byte-wide register port with three addresses. The command address takes the start-of-setup word, end-of-service commands and status-select commands. The data address first takes the rest of the setup words and then holds the mask. The trigger address holds a per-input edge or level choice.

After the start-of-setup word, the next data-address writes are taken in a fixed order: the vector base, then the cascade word (which is accepted and discarded), then the mode word if the start word asked for one. Only after that does a data-address write reach the mask. When the processor raises the acknowledge strobe, the highest-priority eligible request moves into the in-service register. The vector (base plus input number) then appears on the vector output for one cycle. An input stays blocked by any in-service input of equal or higher priority until an end-of-service command retires that input.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Reset clears the request and in-service registers and the trigger register. It sets the mask to all ones and the status select to requests. It leaves int_req and vec_valid low.
- R2: A command-address write with bit 4 set starts setup. It clears in-service, sets the mask to all ones, selects request status and restarts the word order. Its bit 3 makes every input level-sensitive and its bit 0 requests a mode word.
- R3: Data-address writes after the start word go to vector base, then cascade, then mode (only if requested); later data-address writes load the mask, readable at the data address.
- R4: The clock edge that samples inta with an eligible request loads vec_out with vector base plus the input number and raises vec_valid for one cycle.
- R5: On acknowledge, the lowest-numbered eligible request is moved into in-service.
- R6: A request is eligible when its mask bit is 0 and its number is lower than every set in-service bit; int_req is high exactly while an eligible request exists, derived from registers only.
- R7: A mask bit of 1 keeps that input from raising int_req, while its request bit still records the event.
- R8: An edge-mode input sets its request bit on a rising edge. The bit stays set after the input falls and is cleared by acknowledge.
- R9: Trigger-address bit n at 1 makes input n level-sensitive: its request bit follows the input one cycle later; the register reads back.
- R10: Command byte 0x20 clears the lowest-numbered set in-service bit; other command bytes with bits 4 and 3 clear have no effect.
- R11: A command byte with bit 4 clear and bit 3 set and low bits 11 selects in-service for command-address reads, low bits 10 selects requests, and low bits 0x leave the select unchanged. Read data appears after the edge sampling bus_rd.
- R12: An acknowledge with no eligible request leaves vec_valid low and in-service unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | 0 command, 1 data, 2 trigger select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_in | input | 8 | Interrupt inputs, bit 0 highest priority |
| inta | input | 1 | Acknowledge strobe |
| int_req | output | 1 | Eligible request pending |
| vec_out | output | 8 | Vector of the acknowledged input |
| vec_valid | output | 1 | vec_out valid this cycle |

## Verification
The hardest state to reach is nesting. A lower-priority request must be in service while a higher one arrives and is served. Then a third request, equal in priority to the older in-service input, must stay blocked across end-of-service commands. The stimulus gets there by acknowledging input 3 and raising input 2, then acknowledging it. It then pulses input 3 again, which shows that int_req stays low until both in-service bits are retired one at a time by end-of-service commands. Switching the same inputs between edge and level triggering, and redoing setup without a mode word, covers the remaining setup paths.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    STEP_DONE = 2'd0,
    STEP_VEC  = 2'd1,
    STEP_CAS  = 2'd2,
    STEP_MODE = 2'd3
  } init_step_t;

  localparam logic [1:0] ADDR_CMD  = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_TRIG = 2'd2;
  localparam logic [7:0] CMD_EOI   = 8'h20;
endpackage

// File: rtl/pic_cfg.sv
module pic_cfg
  import pic_pkg::*;
#(
  parameter int N_IN   = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [N_IN-1:0]   irr,
  input  logic [N_IN-1:0]   isr,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_IN-1:0]   mask,
  output logic [N_IN-1:0]   lvl_sel,
  output logic [DATA_W-1:0] vec_base,
  output logic              eoi_cmd,
  output logic              init_cmd
);
  init_step_t          step_q;
  logic                need_mode_q, level_all_q, sel_isr_q;
  logic [N_IN-1:0]     trig_q;
  logic [DATA_W-1:0]   rd_mux;
  logic                wr_cmd, wr_data, wr_trig;

  assign wr_cmd   = bus_wr && (bus_addr == ADDR_CMD);
  assign wr_data  = bus_wr && (bus_addr == ADDR_DATA);
  assign wr_trig  = bus_wr && (bus_addr == ADDR_TRIG);
  assign init_cmd = wr_cmd && bus_wdata[4];
  assign eoi_cmd  = wr_cmd && (bus_wdata == DATA_W'(CMD_EOI));
  assign lvl_sel  = trig_q | {N_IN{level_all_q}};

  always_comb begin
    case (bus_addr)
      ADDR_CMD:  rd_mux = DATA_W'(sel_isr_q ? isr : irr);
      ADDR_DATA: rd_mux = DATA_W'(mask);
      ADDR_TRIG: rd_mux = DATA_W'(trig_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q      <= STEP_DONE;
      need_mode_q <= 1'b0;
      level_all_q <= 1'b0;
      sel_isr_q   <= 1'b0;
      mask        <= '1;
      trig_q      <= '0;
      vec_base    <= '0;
      bus_rdata   <= '0;
    end else begin
      if (init_cmd) begin
        step_q      <= STEP_VEC;
        level_all_q <= bus_wdata[3];
        need_mode_q <= bus_wdata[0];
        mask        <= '1;
        sel_isr_q   <= 1'b0;
      end else if (wr_cmd && bus_wdata[3] && bus_wdata[1]) begin
        sel_isr_q <= bus_wdata[0];
      end
      if (wr_data) begin
        case (step_q)
          STEP_VEC: begin
            vec_base <= bus_wdata;
            step_q   <= STEP_CAS;
          end
          STEP_CAS:  step_q <= need_mode_q ? STEP_MODE : STEP_DONE;
          STEP_MODE: step_q <= STEP_DONE;
          default:   mask   <= bus_wdata[N_IN-1:0];
        endcase
      end
      if (wr_trig) trig_q <= bus_wdata[N_IN-1:0];
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/pic_req.sv
module pic_req #(
  parameter int N_IN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] irq_in,
  input  logic [N_IN-1:0] lvl_sel,
  input  logic [N_IN-1:0] ack_bit,
  output logic [N_IN-1:0] irr
);
  logic [N_IN-1:0] prev_q;

  for (genvar g = 0; g < N_IN; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q[g] <= 1'b0;
        irr[g]    <= 1'b0;
      end else begin
        prev_q[g] <= irq_in[g];
        if (lvl_sel[g])
          irr[g] <= irq_in[g];
        else if (irq_in[g] && !prev_q[g])
          irr[g] <= 1'b1;
        else if (ack_bit[g])
          irr[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pic_resolve.sv
module pic_resolve #(
  parameter int N_IN  = 8,
  parameter int IDX_W = $clog2(N_IN)
) (
  input  logic [N_IN-1:0]  irr,
  input  logic [N_IN-1:0]  isr,
  input  logic [N_IN-1:0]  mask,
  output logic [N_IN-1:0]  pick,
  output logic [IDX_W-1:0] pick_idx,
  output logic             any_elig
);
  logic [N_IN-1:0] allowed, elig;

  always_comb begin
    allowed  = (isr == '0) ? '1 : ((isr & (~isr + N_IN'(1))) - N_IN'(1));
    elig     = irr & ~mask & allowed;
    pick     = elig & (~elig + N_IN'(1));
    any_elig = |elig;
    pick_idx = '0;
    for (int i = N_IN - 1; i >= 0; i--)
      if (elig[i]) pick_idx = IDX_W'(i);
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_IN   = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_IN-1:0]   irq_in,
  input  logic              inta,
  output logic              int_req,
  output logic [DATA_W-1:0] vec_out,
  output logic              vec_valid
);
  localparam int IDX_W = $clog2(N_IN);

  logic [N_IN-1:0]   isr_q, irr_w, mask_w, lvl_w, pick_w, ack_bit, eoi_clr;
  logic [DATA_W-1:0] base_w;
  logic [IDX_W-1:0]  idx_w;
  logic              any_w, eoi_w, init_w, ack_w;

  pic_cfg #(.N_IN(N_IN), .DATA_W(DATA_W)) cfg_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .irr(irr_w), .isr(isr_q), .bus_rdata(bus_rdata),
    .mask(mask_w), .lvl_sel(lvl_w), .vec_base(base_w), .eoi_cmd(eoi_w),
    .init_cmd(init_w)
  );

  pic_req #(.N_IN(N_IN)) req_i (
    .clk(clk), .rst(rst), .irq_in(irq_in), .lvl_sel(lvl_w),
    .ack_bit(ack_bit), .irr(irr_w)
  );

  pic_resolve #(.N_IN(N_IN)) res_i (
    .irr(irr_w), .isr(isr_q), .mask(mask_w), .pick(pick_w),
    .pick_idx(idx_w), .any_elig(any_w)
  );

  assign ack_w   = inta && any_w;
  assign ack_bit = ack_w ? pick_w : '0;
  assign eoi_clr = eoi_w ? (isr_q & (~isr_q + N_IN'(1))) : '0;
  assign int_req = any_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q     <= '0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      if (init_w) isr_q <= '0;
      else        isr_q <= (isr_q & ~eoi_clr) | ack_bit;
      vec_valid <= ack_w;
      if (ack_w) vec_out <= base_w + DATA_W'(idx_w);
    end
  end
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int N_IN = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            inta,
  input logic            int_req,
  input logic            vec_valid,
  input logic [N_IN-1:0] isr,
  input logic [N_IN-1:0] irr,
  input logic [N_IN-1:0] mask,
  input logic            eoi
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (isr == '0 && irr == '0 && mask == '1 && !vec_valid));

  assert_vec_needs_ack_R4: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> ($past(inta) && $past(int_req)));

  assert_isr_grows_by_one_R5: assert property (@(posedge clk) disable iff (rst)
    $countones(isr) <= $countones($past(isr)) + 1);

  assert_req_has_source_R6: assert property (@(posedge clk) disable iff (rst)
    int_req |-> ((irr & ~mask) != '0));

  assert_eoi_retires_one_R10: assert property (@(posedge clk) disable iff (rst)
    (eoi && !inta && isr != '0) |=> ($countones(isr) == $countones($past(isr)) - 1));

  assert_idle_ack_no_vec_R12: assert property (@(posedge clk) disable iff (rst)
    (inta && !int_req) |=> !vec_valid);
endmodule

bind prio_irq_ctrl pic_checker #(.N_IN(N_IN)) chk_i (
  .clk(clk), .rst(rst), .inta(inta), .int_req(int_req), .vec_valid(vec_valid),
  .isr(isr_q), .irr(irr_w), .mask(mask_w), .eoi(eoi_w)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int NV    = 57;
  // entry: op[27:24] addr[23:20] data[19:12] exp[11:4] req[3:0]
  // op: 0 write, 1 read+check, 2 drive inputs, 3 ack+vector, 4 ack no vector, 5 int_req check
  localparam logic [27:0] TBL [NV] = '{
    28'h5_0_00_00_1, // R1 int_req low after reset
    28'h1_1_00_FF_1, // R1 mask all ones
    28'h0_0_11_00_2, // R2 start setup, edge, mode word
    28'h0_1_40_00_3, // R3 vector base
    28'h0_1_04_00_3, // R3 cascade
    28'h0_1_01_00_3, // R3 mode
    28'h0_1_F0_00_7, // R7 mask
    28'h1_1_00_F0_3, // R3 mask read back
    28'h2_0_20_00_7, // input 5 (masked)
    28'h5_0_00_00_7, // R7 masked keeps int_req low
    28'h1_0_00_20_B, // R11 default request status
    28'h2_0_28_00_8, // input 3 rises
    28'h5_0_00_01_8, // R8
    28'h2_0_20_00_8, // input 3 falls
    28'h5_0_00_01_8, // R8 latched
    28'h3_0_00_43_4, // R4 vector 0x43
    28'h5_0_00_00_6, // R6
    28'h0_0_0B_00_B, // R11 select in-service
    28'h1_0_00_08_B, // R11
    28'h2_0_24_00_6, // input 2 rises
    28'h5_0_00_01_6, // R6 nesting higher priority
    28'h3_0_00_42_5, // R5
    28'h1_0_00_0C_5, // R5 two in service
    28'h2_0_2C_00_6, // input 3 rises again
    28'h5_0_00_00_6, // R6 blocked
    28'h0_0_60_00_A, // R10 other command no effect
    28'h1_0_00_0C_A, // R10
    28'h0_0_20_00_A, // R10 end of service
    28'h1_0_00_08_A, // R10 lowest bit retired
    28'h5_0_00_00_6, // R6 equal priority blocked
    28'h0_0_20_00_A, // R10
    28'h5_0_00_01_6, // R6
    28'h0_0_0A_00_B, // R11 select requests
    28'h1_0_00_28_B, // R11
    28'h3_0_00_43_5, // R5
    28'h4_0_00_00_C, // R12 idle acknowledge
    28'h0_0_20_00_A, // R10
    28'h2_0_00_00_8, // inputs low
    28'h0_2_02_00_9, // R9 input 1 level
    28'h1_2_00_02_9, // R9 read back
    28'h2_0_02_00_9, // input 1 high
    28'h5_0_00_01_9, // R9
    28'h2_0_00_00_9, // input 1 low
    28'h5_0_00_00_9, // R9 follows level
    28'h1_0_00_20_8, // R8 edge bit 5 still held
    28'h0_0_18_00_2, // R2 setup again, level, no mode
    28'h1_1_00_FF_2, // R2 mask all ones
    28'h0_1_80_00_3, // R3 base
    28'h0_1_00_00_3, // R3 cascade
    28'h0_1_FE_00_3, // R3 goes to mask without mode word
    28'h1_1_00_FE_3, // R3
    28'h2_0_01_00_2, // input 0 high
    28'h5_0_00_01_2, // R2
    28'h3_0_00_80_4, // R4 vector 0x80
    28'h0_0_20_00_A, // R10
    28'h2_0_00_00_2, // input 0 low
    28'h5_0_00_00_2  // R2 global level follows input
  };

  logic       clk = 1'b0, rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, inta = 1'b0;
  logic [7:0] bus_wdata = '0, irq_in = '0;
  logic [7:0] bus_rdata, vec_out;
  logic       int_req, vec_valid;
  int         n_chk = 0, n_bad = 0;

  always #(CLK_P / 2) clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .inta(inta),
    .int_req(int_req), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  task automatic check(input logic ok, input int req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] e, input int req);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    check(bus_rdata == e, req, bus_rdata, e);
  endtask

  task automatic drive(input logic [7:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk);
  endtask

  task automatic ack(output logic v, output logic [7:0] vec);
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0;
    v = vec_valid; vec = vec_out;
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic       v;
    logic [7:0] vec;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      logic [3:0] op, req;
      logic [1:0] a;
      logic [7:0] d, e;
      op = TBL[i][27:24]; a = TBL[i][21:20]; d = TBL[i][19:12];
      e = TBL[i][11:4]; req = TBL[i][3:0];
      case (op)
        4'h0: wr(a, d);
        4'h1: rd_chk(a, e, int'(req));
        4'h2: drive(d);
        4'h3: begin ack(v, vec); check(v && vec == e, int'(req), {v, vec}, {1'b1, e}); end
        4'h4: begin ack(v, vec); check(!v, int'(req), v, 0); end
        default: begin @(negedge clk); check(int_req == e[0], int'(req), int_req, e[0]); end
      endcase
    end
    // R11: select commands with low bits 0x are ignored
    drive(8'h01);
    ack(v, vec);
    check(v && vec == 8'h80, 5, vec, 8'h80);   // R5
    drive(8'h00);
    wr(2'd0, 8'h0B);
    wr(2'd0, 8'h08);
    rd_chk(2'd0, 8'h01, 11);                   // R11 still in-service
    wr(2'd0, 8'h0A);
    rd_chk(2'd0, 8'h00, 11);                   // R11 requests
    // R1: reset in the middle of service
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    check(!int_req && !vec_valid, 1, {int_req, vec_valid}, 0); // R1
    rd_chk(2'd1, 8'hFF, 1);                    // R1 mask
    rd_chk(2'd2, 8'h00, 1);                    // R1 trigger register
    wr(2'd0, 8'h0B);
    rd_chk(2'd0, 8'h00, 1);                    // R1 in-service cleared
    finish_run();
  end
endmodule